// File: doc/BRIEF.md
# Byte-Stream Packet Router, One Input to Three Outputs

This block takes a stream of byte-wide packets on a single input and steers each one into one of three output queues. The header byte names the destination queue and the number of payload bytes that follow. The last byte of each packet is a check byte, which the router compares against its own running parity. Every accepted byte first lands in a one-byte holding register. A small state machine walks through the header, payload and check phases. The held byte is then written into the queue of the destination that the header chose.

Each output has a 16-entry first-word-fall-through queue with its own valid/read handshake. When the destination queue is full, the router raises busy and the sender must keep its byte steady. The header, the payload and the check byte are all stored, so a reader sees the whole packet. A queue that keeps unread data for too long with no read is flushed on its own. This stops an abandoned output from stalling the input forever.

Top module: `pkt_router`

## Requirements
- R1: The header byte gives the destination in bits [1:0] (0, 1 or 2) and the payload count N in bits [7:2] (0 to 63). The packet is the header, then N payload bytes, then one check byte. All N+2 bytes appear, in order, on the chosen output and on no other output.
- R2: A header whose destination field is 3 causes the whole packet (all N+2 bytes) to be consumed without being written to any output queue.
- R3: The expected check byte is the XOR of the header and all payload bytes. If the received check byte differs, err is high for exactly the one cycle after the check byte is accepted. Otherwise err stays low.
- R4: An input byte is accepted at a rising edge where in_valid is high and busy is low. busy is high only while the holding register keeps a byte whose destination queue is full. During that time the held byte is kept unchanged, and nothing is lost.
- R5: Each output queue holds 16 bytes. out_valid is high while it holds data, and out_data shows the oldest byte. A rising edge with rd_en and out_valid both high removes that byte.
- R6: A queue counts the cycles in which it holds data and is not read. When 30 such cycles have occurred in a row, the queue is emptied: out_valid is seen high for exactly 30 cycles.
- R7: rst_n low at a rising edge (synchronous) empties all queues, clears the holding register and the parser, and drives busy and err low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| busy | output | 1 | Input must hold its byte |
| err | output | 1 | Check byte mismatch pulse |
| rd_en | input | 3 | Read strobe, one per output |
| out_valid | output | 3 | Output queue not empty, one per output |
| out_data | output | 3x8 | Oldest byte of each output queue |

## Verification
Random packets go to all four destination codes, with random lengths, random gaps between input bytes and random read patterns. One packet in four carries a corrupted check byte. This separates correct steering, ordering and parity from errors that only show with back-to-back traffic or a slow reader. Directed cases stop the reader so a long packet fills a queue; they then count accepted bytes when busy rises, which shows no byte is lost or repeated at the full boundary. A stalled queue is watched cycle by cycle to pin the flush to exactly 30 idle cycles. A packet with destination 3 and zero-length packets test the drop path and a parity taken from the header alone.

// File: rtl/pkt_router.sv
module pkt_router #(
  parameter int W       = 8,
  parameter int DEPTH   = 16,
  parameter int TIMEOUT = 30
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [W-1:0]        in_data,
  output logic                busy,
  output logic                err,
  input  logic [2:0]          rd_en,
  output logic [2:0]          out_valid,
  output logic [2:0][W-1:0]   out_data
);
  localparam int NP = 3;
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int LW = W - 2;
  localparam int TW = $clog2(TIMEOUT + 1);

  typedef enum logic [1:0] {S_HEAD, S_BODY, S_PAR} st_t;

  st_t                  st;
  logic [LW-1:0]        rem;
  logic [W-1:0]         par;
  logic [W-1:0]         hold_q;
  logic                 hold_vld;
  logic [1:0]           dst_q;
  logic                 err_q;
  logic [3:0]           full_x;
  logic [NP-1:0]        wr_en;
  logic [NP-1:0][CW-1:0] cnt_v;
  logic                 accept, drain;

  assign full_x[3] = 1'b0;
  assign drain     = hold_vld && !full_x[dst_q];
  assign busy      = hold_vld && !drain;
  assign accept    = in_valid && !busy;
  assign err       = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_HEAD;
      rem      <= '0;
      par      <= '0;
      dst_q    <= '0;
      hold_q   <= '0;
      hold_vld <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (accept) begin
        hold_q   <= in_data;
        hold_vld <= 1'b1;
        case (st)
          S_HEAD: begin
            dst_q <= in_data[1:0];
            rem   <= in_data[W-1:2];
            par   <= in_data;
            st    <= (in_data[W-1:2] == '0) ? S_PAR : S_BODY;
          end
          S_BODY: begin
            par <= par ^ in_data;
            rem <= rem - 1'b1;
            if (rem == LW'(1)) st <= S_PAR;
          end
          default: begin
            err_q <= (in_data != par);
            st    <= S_HEAD;
          end
        endcase
      end else if (drain) begin
        hold_vld <= 1'b0;
      end
    end
  end

  for (genvar i = 0; i < NP; i++) begin : g_q
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic [TW-1:0] idle;
    logic          pop, flush;

    assign wr_en[i]     = drain && (dst_q == 2'(i));
    assign pop          = rd_en[i] && (cnt != '0);
    assign flush        = (cnt != '0) && !pop && (idle == TW'(TIMEOUT - 1));
    assign out_valid[i] = (cnt != '0);
    assign out_data[i]  = mem[rp];
    assign full_x[i]    = (cnt == CW'(DEPTH));
    assign cnt_v[i]     = cnt;

    always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
        wp   <= '0;
        rp   <= '0;
        cnt  <= '0;
        idle <= '0;
      end else begin
        wp   <= wp + AW'(wr_en[i]);
        rp   <= rp + AW'(pop);
        cnt  <= cnt + CW'(wr_en[i]) - CW'(pop);
        idle <= ((cnt != '0) && !pop) ? idle + 1'b1 : '0;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_en[i]) mem[wp] <= hold_q;
    end
  end
endmodule

// File: rtl/pkt_router_chk.sv
module pkt_router_chk #(
  parameter int W       = 8,
  parameter int DEPTH   = 16,
  parameter int TIMEOUT = 30
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          busy,
  input logic                          err,
  input logic [2:0]                    rd_en,
  input logic [2:0]                    out_valid,
  input logic [W-1:0]                  hold_q,
  input logic [2:0][$clog2(DEPTH):0]   cnt_v
);
  localparam int CW = $clog2(DEPTH) + 1;

  p_err_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

  p_busy_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(hold_q));

  p_reset_clear_r7: assert property (@(posedge clk)
    !rst_n |=> (!busy && !err && out_valid == 3'b000));

  for (genvar i = 0; i < 3; i++) begin : g_c
    logic [7:0] stall;
    always_ff @(posedge clk) begin
      if (!rst_n) stall <= '0;
      else stall <= (out_valid[i] && !rd_en[i]) ? stall + 1'b1 : '0;
    end

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_v[i] <= CW'(DEPTH));

    p_one_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_v[i] == '0) |=> (cnt_v[i] <= CW'(1)));

    p_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (stall == 8'(TIMEOUT)) |-> !out_valid[i]);
  end
endmodule

bind pkt_router pkt_router_chk #(.W(W), .DEPTH(DEPTH), .TIMEOUT(TIMEOUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .err(err), .rd_en(rd_en),
  .out_valid(out_valid), .hold_q(hold_q), .cnt_v(cnt_v)
);

// File: tb/pkt_router_tb.sv
module pkt_router_tb;
  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic [7:0]       in_data = '0;
  logic             busy, err;
  logic [2:0]       rd_en = '0;
  logic [2:0]       out_valid;
  logic [2:0][7:0]  out_data;

  int   n_chk = 0, n_bad = 0;
  int   accepted = 0;
  bit   reader_on = 1'b0;
  bit   done = 1'b0;
  logic [7:0] q [3][$];

  always #4 clk = ~clk;

  pkt_router u_dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .busy(busy), .err(err), .rd_en(rd_en), .out_valid(out_valid), .out_data(out_data));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] hdr(input int dst, input int len);
    return {6'(len), 2'(dst)};
  endfunction

  function automatic logic [7:0] xsum(input logic [7:0] b[$]);
    logic [7:0] s = '0;
    foreach (b[k]) s ^= b[k];
    return s;
  endfunction

  task automatic send_byte(input logic [7:0] b, input int dst);
    if (dst < 3) q[dst].push_back(b);
    in_data  = b;
    in_valid = 1'b1;
    while (busy) @(negedge clk);
    @(negedge clk);
    accepted++;
    in_valid = 1'b0;
  endtask

  task automatic send_pkt(input int dst, input int len, input bit bad, input bit gaps);
    logic [7:0] b[$];
    logic [7:0] p;
    b.push_back(hdr(dst, len));
    for (int k = 0; k < len; k++) b.push_back(8'($urandom));
    p = xsum(b);
    if (bad) p ^= 8'(1 + $urandom % 255);
    b.push_back(p);
    foreach (b[k]) begin
      send_byte(b[k], dst);
      if (k == b.size() - 1) begin
        chk(err == bad, "R3 err after check byte", int'(err), int'(bad));
        @(negedge clk);
        chk(err == 1'b0, "R3 err one cycle only", int'(err), 0);
      end else if (gaps && ($urandom % 4 == 0)) begin
        @(negedge clk);
      end
    end
  endtask

  // reader: drives rd_en and compares popped bytes against the model (R1, R5)
  initial begin
    int since [3] = '{0, 0, 0};
    forever begin
      @(negedge clk);
      for (int i = 0; i < 3; i++) begin
        bit rd;
        rd = reader_on && (($urandom % 10 < 7) || since[i] >= 8);
        rd_en[i] = rd;
        since[i] = rd ? 0 : since[i] + 1;
        if (rd && out_valid[i]) begin
          if (q[i].size() == 0) begin
            chk(1'b0, "R1 unexpected byte on output", int'(out_data[i]), -1);
          end else begin
            logic [7:0] e;
            e = q[i].pop_front();
            chk(out_data[i] == e, "R1 R5 byte order/data", int'(out_data[i]), int'(e));
          end
        end
      end
    end
  end

  task automatic wait_drain;
    for (int t = 0; t < 3000; t++) begin
      if (q[0].size() == 0 && q[1].size() == 0 && q[2].size() == 0) break;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(busy == 0 && err == 0 && out_valid == 3'b000, "R7 reset state", int'({busy, err, out_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    reader_on = 1'b1;

    // directed: zero payload and maximum payload
    send_pkt(0, 0, 1'b0, 1'b0);
    send_pkt(2, 63, 1'b0, 1'b0);
    send_pkt(1, 0, 1'b1, 1'b0);
    wait_drain();

    // R2: destination 3 dropped
    send_pkt(3, 5, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    chk(out_valid == 3'b000, "R2 dropped packet reaches no output", int'(out_valid), 0);
    send_pkt(3, 2, 1'b1, 1'b0);
    repeat (4) @(negedge clk);
    chk(out_valid == 3'b000, "R2 dropped bad packet reaches no output", int'(out_valid), 0);

    // random traffic
    for (int n = 0; n < 60; n++) begin
      int d, l;
      d = $urandom % 4;
      l = ($urandom % 5 == 0) ? $urandom % 64 : $urandom % 12;
      send_pkt(d, l, ($urandom % 4 == 0), 1'b1);
    end
    wait_drain();
    for (int i = 0; i < 3; i++)
      chk(q[i].size() == 0, "R1 every byte delivered", q[i].size(), 0);

    // R4: stalled reader fills queue 1, busy appears at the full boundary
    reader_on = 1'b0;
    @(negedge clk);
    accepted = 0;
    fork
      send_pkt(1, 24, 1'b0, 1'b0);
      begin
        while (!busy) @(negedge clk);
        #1;
        chk(accepted == 17, "R4 bytes accepted when busy rises", accepted, 17);
        chk(out_valid[1] == 1'b1, "R4 queue holds data while busy", int'(out_valid[1]), 1);
        repeat (3) @(negedge clk);
        #1;
        chk(accepted == 17 && busy, "R4 no byte taken while busy", accepted, 17);
        reader_on = 1'b1;
      end
    join
    wait_drain();
    chk(q[1].size() == 0, "R4 no byte lost across busy", q[1].size(), 0);

    // R6: unread queue 0 is flushed after 30 idle cycles
    reader_on = 1'b0;
    @(negedge clk);
    begin
      int seen = 0;
      fork
        send_pkt(0, 3, 1'b0, 1'b0);
        begin
          while (!out_valid[0]) @(negedge clk);
          while (out_valid[0] && seen < 100) begin
            seen++;
            @(negedge clk);
          end
        end
      join
      chk(seen == 30, "R6 cycles valid before flush", seen, 30);
      chk(out_valid[0] == 1'b0, "R6 queue empty after flush", int'(out_valid[0]), 0);
      q[0].delete();
    end

    // R7: reset mid-packet clears queues
    send_byte(hdr(2, 5), 2);
    send_byte(8'h3c, 2);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk(out_valid == 3'b000 && busy == 0, "R7 reset clears queues", int'(out_valid), 0);
    q[2].delete();
    reader_on = 1'b1;
    send_pkt(2, 4, 1'b0, 1'b0);
    wait_drain();
    chk(q[2].size() == 0, "R7 parser restarts at header", q[2].size(), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule